// File: doc/BRIEF.md
# Fetch Branch Target Cache

This block sits in an instruction fetch stage and remembers where recently resolved direct branches went. Fetch addresses are held as word addresses (byte address shifted right by two). Each cycle the block presents the word address being fetched. When the fetch stage advances, the block normally steps that address by one word. If a remembered branch sits at the current address and was last seen taken, the block marks the current instruction as predicted-taken and fetches the remembered target next, so decode can skip its own static guess for that instruction.

The store is direct-mapped, with 1024 entries by default, indexed by the low word-address bits, which correspond to byte-address bits 11 to 2. Each entry keeps the full word address of the branch as a tag, the full target word address and a valid bit. The execute stage reports every resolved direct branch. Each report writes the entry for that branch, and the valid bit records the outcome: taken sets it, not-taken clears it. To keep the read off the fetch critical path, the entry is read one fetch ahead of use. As a result, the first two instructions after an external redirect are never predicted.

A later stage can force fetch to any address at any time. That redirect wins over a prediction and discards the lookups in flight. A build-time parameter removes the whole cache, which leaves plain sequential fetch plus external redirects.

Top module: `fetch_btc`

## Requirements
- R1: While reset is high and on the first cycle after it, `fetch_word` equals `RESET_WORD` and `pred_taken` is low. Reset invalidates every entry, so no address is predicted until an update marks it taken.
- R2: With `fetch_adv` high, no redirect and no prediction, `fetch_word` steps by exactly one word on the next cycle.
- R3: If the entry looked up for the current address is valid and its stored branch word equals `fetch_word`, then `pred_taken` is high in that cycle. If `fetch_adv` is also high, the next `fetch_word` is the stored target.
- R4: An entry whose stored branch word differs from `fetch_word` produces no prediction, even though it shares the index. Index = `fetch_word[IDX_W-1:0]`.
- R5: An update with `upd_taken` high makes its branch predictable. An update with `upd_taken` low clears the valid bit of that index, so a later pass over that branch is not predicted.
- R6: After an external redirect to word R, the words R and R+1 are never predicted. Word R+2 reached by sequential fetch is predicted when its entry says so.
- R7: After a predicted redirect to target T, T itself is not predicted. T+1 reached sequentially can be predicted.
- R8: When `redir_valid` is high, `pred_taken` is low in that cycle and the next `fetch_word` is `redir_word`, whatever `fetch_adv` and the cache say.
- R9: The prediction at an address uses the entry as it stood before the clock edge that advanced fetch onto that address. An update presented in the same cycle as that advance is not seen by that lookup.
- R10: With `fetch_adv` low and no redirect, `fetch_word` and `pred_taken` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_adv | input | 1 | Fetch accepts the current instruction and moves on |
| redir_valid | input | 1 | External redirect from a later stage |
| redir_word | input | WORD_W | Redirect target word address |
| upd_valid | input | 1 | Resolved direct branch report from execute |
| upd_taken | input | 1 | Outcome of the reported branch (1 = taken) |
| upd_word | input | WORD_W | Word address of the reported branch |
| upd_tgt_word | input | WORD_W | Target word address of the reported branch |
| fetch_word | output | WORD_W | Word address being fetched this cycle |
| pred_taken | output | 1 | Current instruction is predicted as a taken branch |

## Verification
The block has two kinds of result. `pred_taken` depends combinationally on the present state and on `redir_valid` in the same cycle. `fetch_word` changes on the first rising edge after its controlling inputs. The bench drives inputs just after a falling edge, samples both outputs one time unit later within that same cycle, and compares them with a reference model that it steps once per cycle. The cache contents the model uses for a prediction are captured at the advance onto that address and exclude that cycle's update. This matches R9, under which an update becomes visible to a lookup only if it was presented before the advance edge that reads the entry.

// File: rtl/btc_pkg.sv
package btc_pkg;

    localparam int unsigned BTC_WORD_W = 30;
    localparam int unsigned BTC_IDX_W  = 10;

    typedef enum logic [1:0] {
        NXT_HOLD  = 2'd0,
        NXT_SEQ   = 2'd1,
        NXT_PRED  = 2'd2,
        NXT_REDIR = 2'd3
    } nxt_src_e;

    function automatic nxt_src_e pick_src(input logic redir, input logic adv, input logic hit);
        if (redir) begin
            return NXT_REDIR;
        end
        if (!adv) begin
            return NXT_HOLD;
        end
        if (hit) begin
            return NXT_PRED;
        end
        return NXT_SEQ;
    endfunction

endpackage

// File: rtl/btc_store.sv
module btc_store #(
    parameter int unsigned WORD_W = btc_pkg::BTC_WORD_W,
    parameter int unsigned IDX_W  = btc_pkg::BTC_IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_taken,
    input  logic [WORD_W-1:0] wr_tag,
    input  logic [WORD_W-1:0] wr_tgt,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [WORD_W-1:0] rd_tag,
    output logic [WORD_W-1:0] rd_tgt
);
    localparam int unsigned ENTRIES = 1 << IDX_W;

    logic [IDX_W-1:0]  wr_idx;
    logic [ENTRIES-1:0] vld_q;
    logic [WORD_W-1:0] tag_mem [ENTRIES];
    logic [WORD_W-1:0] tgt_mem [ENTRIES];

    assign wr_idx = wr_tag[IDX_W-1:0];

    // Valid bits live in flops so reset can clear them all at once.
    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= wr_taken;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
            tgt_mem[wr_idx] <= wr_tgt;
        end
    end

    // Synchronous read: a write in the same cycle is not visible here.
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
        end else if (rd_en) begin
            rd_valid <= vld_q[rd_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_tag <= tag_mem[rd_idx];
            rd_tgt <= tgt_mem[rd_idx];
        end
    end

    AST_UPD_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (vld_q[$past(wr_idx)] == $past(wr_taken))); // R5

endmodule

// File: rtl/btc_match.sv
module btc_match #(
    parameter int unsigned WORD_W = btc_pkg::BTC_WORD_W
) (
    input  logic              lk_ok,
    input  logic              lk_valid,
    input  logic [WORD_W-1:0] lk_tag,
    input  logic [WORD_W-1:0] cur_word,
    output logic              hit
);
    // Full-word tag compare: an aliasing branch on the same index never matches.
    always_comb begin
        hit = lk_ok && lk_valid && (lk_tag == cur_word);
    end

endmodule

// File: rtl/fetch_btc.sv
module fetch_btc
    import btc_pkg::*;
#(
    parameter int unsigned WORD_W     = BTC_WORD_W,
    parameter int unsigned IDX_W      = BTC_IDX_W,
    parameter bit          BTC_EN     = 1'b1,
    parameter logic [WORD_W-1:0] RESET_WORD = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_adv,
    input  logic              redir_valid,
    input  logic [WORD_W-1:0] redir_word,
    input  logic              upd_valid,
    input  logic              upd_taken,
    input  logic [WORD_W-1:0] upd_word,
    input  logic [WORD_W-1:0] upd_tgt_word,
    output logic [WORD_W-1:0] fetch_word,
    output logic              pred_taken
);
    logic [WORD_W-1:0] nia_q;
    logic [WORD_W-1:0] nxt_word;
    logic [WORD_W-1:0] hit_tgt;
    logic              hit;
    nxt_src_e          src;

    always_comb begin
        src = pick_src(redir_valid, fetch_adv, hit);
        unique case (src)
            NXT_REDIR: nxt_word = redir_word;
            NXT_PRED:  nxt_word = hit_tgt;
            NXT_SEQ:   nxt_word = nia_q + WORD_W'(1);
            default:   nxt_word = nia_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            nia_q <= RESET_WORD;
        end else begin
            nia_q <= nxt_word;
        end
    end

    assign fetch_word = nia_q;
    assign pred_taken = hit && !redir_valid;

    generate
        if (BTC_EN) begin : g_btc
            logic             s1_ok;
            logic             s2_ok;
            logic [IDX_W-1:0] s1_idx;
            logic             adv_go;
            logic             rd_valid;
            logic [WORD_W-1:0] rd_tag;
            logic [WORD_W-1:0] rd_tgt;

            assign adv_go = (src == NXT_SEQ) || (src == NXT_PRED);

            // s1 holds the index of the word after the next fetch; the store
            // reads it on the advance so the data is ready one fetch later.
            always_ff @(posedge clk) begin
                if (rst) begin
                    s1_ok  <= 1'b0;
                    s2_ok  <= 1'b0;
                    s1_idx <= '0;
                end else if (redir_valid) begin
                    s1_ok <= 1'b0;
                    s2_ok <= 1'b0;
                end else if (adv_go) begin
                    s1_ok  <= 1'b1;
                    s1_idx <= IDX_W'(nxt_word + WORD_W'(1));
                    s2_ok  <= (src == NXT_PRED) ? 1'b0 : s1_ok;
                end
            end

            btc_store #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_store (
                .clk      (clk),
                .rst      (rst),
                .wr_en    (upd_valid),
                .wr_taken (upd_taken),
                .wr_tag   (upd_word),
                .wr_tgt   (upd_tgt_word),
                .rd_en    (adv_go),
                .rd_idx   (s1_idx),
                .rd_valid (rd_valid),
                .rd_tag   (rd_tag),
                .rd_tgt   (rd_tgt)
            );

            btc_match #(.WORD_W(WORD_W)) u_match (
                .lk_ok    (s2_ok),
                .lk_valid (rd_valid),
                .lk_tag   (rd_tag),
                .cur_word (nia_q),
                .hit      (hit)
            );

            assign hit_tgt = rd_tgt;

            AST_REDIR_FLUSH: assert property (@(posedge clk) disable iff (rst)
                redir_valid |=> !s2_ok); // R6

            AST_PRED_RESTART: assert property (@(posedge clk) disable iff (rst)
                (fetch_adv && pred_taken) |=> !hit); // R7
        end else begin : g_no_btc
            assign hit     = 1'b0;
            assign hit_tgt = '0;
        end
    endgenerate

    AST_RST_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ((fetch_word == RESET_WORD) && !pred_taken)); // R1

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (fetch_adv && !redir_valid && !pred_taken) |=>
            (fetch_word == WORD_W'($past(fetch_word) + WORD_W'(1)))); // R2

    AST_PRED_TARGET: assert property (@(posedge clk) disable iff (rst)
        (fetch_adv && pred_taken) |=> (fetch_word == $past(hit_tgt))); // R3

    AST_REDIR_WINS: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> (fetch_word == $past(redir_word))); // R8

    AST_REDIR_NO_PRED: assert property (@(posedge clk) disable iff (rst)
        redir_valid |-> !pred_taken); // R8

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!fetch_adv && !redir_valid) |=> $stable(fetch_word)); // R10

endmodule

// File: tb/fetch_btc_bench.sv
module fetch_btc_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WORD_W     = 30;
    localparam int IDX_W      = 10;
    localparam int ENTRIES    = 1 << IDX_W;
    localparam logic [WORD_W-1:0] RESET_WORD = 30'h100;

    logic              clk = 1'b0;
    logic              rst;
    logic              fetch_adv, redir_valid, upd_valid, upd_taken;
    logic [WORD_W-1:0] redir_word, upd_word, upd_tgt_word;
    logic [WORD_W-1:0] fetch_word;
    logic              pred_taken;

    int n_vec = 0;
    int n_bad = 0;

    bit                m_vld [ENTRIES];
    logic [WORD_W-1:0] m_tag [ENTRIES];
    logic [WORD_W-1:0] m_tgt [ENTRIES];
    logic [WORD_W-1:0] m_nia;
    int                m_streak;
    bit                s_vld;
    logic [WORD_W-1:0] s_tag, s_tgt;

    always #(CLK_PERIOD/2) clk = ~clk;

    fetch_btc #(.WORD_W(WORD_W), .IDX_W(IDX_W), .BTC_EN(1'b1), .RESET_WORD(RESET_WORD)) u_fetch_btc (
        .clk(clk), .rst(rst), .fetch_adv(fetch_adv), .redir_valid(redir_valid),
        .redir_word(redir_word), .upd_valid(upd_valid), .upd_taken(upd_taken),
        .upd_word(upd_word), .upd_tgt_word(upd_tgt_word),
        .fetch_word(fetch_word), .pred_taken(pred_taken)
    );

    function automatic int ix(input logic [WORD_W-1:0] w);
        return int'(w[IDX_W-1:0]);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One cycle: drive inputs after the falling edge, check, step the model.
    task automatic step(input bit adv, input bit rd, input logic [WORD_W-1:0] rw,
                        input bit uv, input bit ut, input logic [WORD_W-1:0] uw,
                        input logic [WORD_W-1:0] utw, input string req);
        bit exp_pred;
        fetch_adv = adv; redir_valid = rd; redir_word = rw;
        upd_valid = uv; upd_taken = ut; upd_word = uw; upd_tgt_word = utw;
        #1;
        exp_pred = !rd && (m_streak == 2) && s_vld && (s_tag == m_nia);
        check(fetch_word == m_nia, req, "fetch_word", fetch_word, m_nia);
        check(pred_taken == exp_pred, req, "pred_taken",
              WORD_W'(pred_taken), WORD_W'(exp_pred));
        if (rd) begin
            m_nia = rw;
            m_streak = 0;
        end else if (adv) begin
            if (exp_pred) begin
                m_nia = s_tgt;
                m_streak = 1;
            end else begin
                m_nia = m_nia + 1'b1;
                if (m_streak < 2) m_streak++;
            end
            s_vld = m_vld[ix(m_nia)];
            s_tag = m_tag[ix(m_nia)];
            s_tgt = m_tgt[ix(m_nia)];
        end
        if (uv) begin
            m_vld[ix(uw)] = ut;
            m_tag[ix(uw)] = uw;
            m_tgt[ix(uw)] = utw;
        end
        @(negedge clk);
    endtask

    task automatic adv1(input string req);
        step(1'b1, 1'b0, '0, 1'b0, 1'b0, '0, '0, req);
    endtask

    task automatic idle(input string req);
        step(1'b0, 1'b0, '0, 1'b0, 1'b0, '0, '0, req);
    endtask

    task automatic redir(input logic [WORD_W-1:0] w, input string req);
        step(1'b0, 1'b1, w, 1'b0, 1'b0, '0, '0, req);
    endtask

    task automatic upd(input logic [WORD_W-1:0] w, input bit tk,
                       input logic [WORD_W-1:0] t, input string req);
        step(1'b0, 1'b0, '0, 1'b1, tk, w, t, req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        rst = 1'b1;
        fetch_adv = 0; redir_valid = 0; redir_word = '0;
        upd_valid = 0; upd_taken = 0; upd_word = '0; upd_tgt_word = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            m_vld[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0;
        end
        m_nia = RESET_WORD; m_streak = 0; s_vld = 0; s_tag = '0; s_tgt = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        check(fetch_word == RESET_WORD, "R1", "fetch_word in reset", fetch_word, RESET_WORD);
        check(!pred_taken, "R1", "pred_taken in reset", WORD_W'(pred_taken), '0);
        rst = 1'b0;
        @(negedge clk);

        // R1 / R2 / R10: reset state, stall, sequential fetch over empty cache
        idle("R1"); idle("R10"); idle("R10");
        for (int i = 0; i < 6; i++) adv1("R2");

        // R6 / R3: entries at 0x200..0x202, only the third fetch is predicted
        upd(30'h200, 1'b1, 30'h300, "R5");
        upd(30'h201, 1'b1, 30'h300, "R5");
        upd(30'h202, 1'b1, 30'h300, "R5");
        upd(30'h300, 1'b1, 30'h350, "R5");
        upd(30'h301, 1'b1, 30'h400, "R5");
        redir(30'h200, "R8");
        adv1("R6"); adv1("R6");
        idle("R10"); idle("R10");
        adv1("R3");
        // R7: target 0x300 not predicted, 0x301 is
        adv1("R7"); adv1("R7");
        adv1("R2");

        // R5: not-taken update clears the entry
        upd(30'h202, 1'b0, 30'h300, "R5");
        redir(30'h200, "R8");
        adv1("R5"); adv1("R5"); adv1("R5");

        // R4: same index, different tag
        upd(30'h202 + ENTRIES, 1'b1, 30'h500, "R4");
        redir(30'h200, "R8");
        adv1("R4"); adv1("R4"); adv1("R4");

        // R8: redirect beats a live prediction
        upd(30'h202, 1'b1, 30'h300, "R5");
        redir(30'h200, "R8");
        adv1("R8"); adv1("R8");
        step(1'b1, 1'b1, 30'h600, 1'b0, 1'b0, '0, '0, "R8");
        adv1("R8");

        // R9: update in the advance cycle is not seen by that lookup
        redir(30'h700, "R9");
        adv1("R9");
        step(1'b1, 1'b0, '0, 1'b1, 1'b1, 30'h702, 30'h780, "R9");
        adv1("R9");
        redir(30'h700, "R9");
        adv1("R9"); adv1("R9"); adv1("R9");

        // Random phase on a small region with aliases
        for (int i = 0; i < 3000; i++) begin
            bit a, r, u, t;
            logic [WORD_W-1:0] rw, uw, tw;
            a  = ($urandom % 100) < 80;
            r  = ($urandom % 100) < 5;
            u  = ($urandom % 100) < 30;
            t  = ($urandom % 100) < 70;
            rw = 30'h800 + WORD_W'($urandom % 32);
            uw = 30'h800 + WORD_W'($urandom % 32) + ((($urandom % 8) == 0) ? WORD_W'(ENTRIES) : '0);
            tw = 30'h800 + WORD_W'($urandom % 32);
            step(a, r, rw, u, t, uw, tw, "R3");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule